// File: doc/BRIEF.md
# Flash Program and Erase Engine

This block owns an on-chip byte array that stands in for the contents of a serial NOR flash, and carries out the storage operations that a command sequencer decodes: byte read, byte program and region erase. The array comes out of reset filled with 0xFF. A program merges the new byte into the stored byte with a bitwise AND, so a bit can only be cleared, unless the `OVERWRITE` parameter is set, in which case the new byte simply replaces the old one.

Erase takes its length from the opcode: a small block, a medium block, one sector or the whole device. The start address is first aligned down to that length, and the engine then writes 0xFF into one byte per cycle, holding `busy` high until the last byte is written and pulsing `done` once. Requests pass through a valid/ready handshake: `req_ready` is low for the whole erase, and a request offered during that time must stay valid with its fields unchanged until it is taken. Reads, programs and unknown opcodes are each taken in a single cycle. The `wr_en` input gates erases, and each erase size has its own capability parameter. Because the array is scaled down for simulation, every length is a parameter.

Top module: `flash_eng`

## Requirements
- R1: After reset every byte of the array reads 0xFF, `busy` is low, `req_ready` is high, and `done`, `err_wp` and `warn_size` are low.
- R2: With `OVERWRITE`=0, a program (opcode 0x02) stores the AND of the old byte and `req_data`.
- R3: With `OVERWRITE`=1, a program stores `req_data` as given, so bits can go from 0 back to 1.
- R4: A program taken while `wr_en` is low pulses `err_wp` for one cycle, starting the cycle after acceptance, and is still applied to the array.
- R5: A read (opcode 0x03) raises `rd_valid` for exactly the cycle after acceptance, with `rd_data` equal to the stored byte at `req_addr`.
- R6: An erase writes 0xFF to a region whose length depends on the opcode: 0x20 gives `SMALL_BYTES`, 0x52 gives `MID_BYTES`, 0xD8 gives `SECTOR_BYTES`, and 0xC7 gives the whole device (`SECTOR_BYTES`*`SECTOR_COUNT`). Bytes outside the region are left unchanged.
- R7: The erase region starts at `req_addr` rounded down to a multiple of the erase length.
- R8: An erase of length L keeps `busy` high, and `req_ready` low, for exactly L cycles after the accepting edge. `done` pulses for one cycle as `busy` falls, and a request held valid during the erase is taken on the first edge at which `busy` is low.
- R9: An erase request taken while `wr_en` is low changes no byte, leaves `busy` low and pulses `err_wp` for one cycle.
- R10: An erase with opcode 0x20 while `CAP_SMALL`=0, or with opcode 0x52 while `CAP_MID`=0, pulses `warn_size` for one cycle and is still carried out. Opcodes 0xD8 and 0xC7 never raise the warning.
- R11: A request with any other opcode is accepted in one cycle and has no effect on the array, `rd_valid`, `busy` or any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine can take a request (low while erasing) |
| req_op | input | 8 | Operation code |
| req_addr | input | ADDR_W | Byte address |
| req_data | input | 8 | Program data |
| wr_en | input | 1 | Write-enable state from the sequencer |
| rd_valid | output | 1 | Read data present (one cycle) |
| rd_data | output | 8 | Read data |
| busy | output | 1 | Erase in progress |
| done | output | 1 | Erase completed (one cycle) |
| err_wp | output | 1 | Program or erase requested with write-enable low (one cycle) |
| warn_size | output | 1 | Erase size not supported by this configuration (one cycle) |

## Verification
The cycle that writes the last erased byte can meet a new request that was held valid throughout the erase. The bench offers a program aimed at the final byte of a sector while that sector is being erased. It then checks three things: that the request is taken in the first cycle in which `busy` reads low, that `done` is seen in that same sample, and that reading the byte back gives the program data ANDed into 0xFF, neither the stale pre-erase value nor plain 0xFF. A second case sends a warned erase size with write-enable low, so that the warning and the protection error fire on the same edge.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;
  localparam logic [7:0] OPC_READ      = 8'h03;
  localparam logic [7:0] OPC_PROG      = 8'h02;
  localparam logic [7:0] OPC_ERASE_SM  = 8'h20;
  localparam logic [7:0] OPC_ERASE_MD  = 8'h52;
  localparam logic [7:0] OPC_ERASE_SEC = 8'hD8;
  localparam logic [7:0] OPC_ERASE_ALL = 8'hC7;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_READ  = 2'd1,
    KIND_PROG  = 2'd2,
    KIND_ERASE = 2'd3
  } req_kind_e;
endpackage

// File: rtl/flash_eng_decode.sv
module flash_eng_decode
  import flash_eng_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int SMALL_BYTES  = 64,
  parameter int MID_BYTES    = 256,
  parameter int SECTOR_BYTES = 512,
  parameter bit CAP_SMALL    = 1'b1,
  parameter bit CAP_MID      = 1'b0
) (
  input  logic [7:0]        op,
  output req_kind_e         kind,
  output logic [ADDR_W-1:0] span_mask,
  output logic              unsupported
);
  localparam logic [ADDR_W-1:0] SM_MASK  = ADDR_W'(SMALL_BYTES - 1);
  localparam logic [ADDR_W-1:0] MD_MASK  = ADDR_W'(MID_BYTES - 1);
  localparam logic [ADDR_W-1:0] SEC_MASK = ADDR_W'(SECTOR_BYTES - 1);

  always_comb begin
    kind        = KIND_NONE;
    span_mask   = '0;
    unsupported = 1'b0;
    case (op)
      OPC_READ: kind = KIND_READ;
      OPC_PROG: kind = KIND_PROG;
      OPC_ERASE_SM: begin
        kind        = KIND_ERASE;
        span_mask   = SM_MASK;
        unsupported = !CAP_SMALL;
      end
      OPC_ERASE_MD: begin
        kind        = KIND_ERASE;
        span_mask   = MD_MASK;
        unsupported = !CAP_MID;
      end
      OPC_ERASE_SEC: begin
        kind      = KIND_ERASE;
        span_mask = SEC_MASK;
      end
      OPC_ERASE_ALL: begin
        kind      = KIND_ERASE;
        span_mask = '1;
      end
      default: kind = KIND_NONE;
    endcase
  end
endmodule

// File: rtl/flash_eng_eraser.sv
module flash_eng_eraser #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] mask,
  output logic              busy,
  output logic              done,
  output logic              fill_en,
  output logic [ADDR_W-1:0] fill_addr
);
  logic [ADDR_W-1:0] base_q, mask_q, cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      base_q <= '0;
      mask_q <= '0;
      cnt_q  <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      done   <= 1'b0;
      base_q <= addr & ~mask;
      mask_q <= mask;
      cnt_q  <= '0;
    end else if (busy) begin
      if (cnt_q == mask_q) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt_q <= cnt_q + ADDR_W'(1);
        done  <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign fill_en   = busy;
  assign fill_addr = base_q | cnt_q;

  assert_done_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != mask_q) |=> (busy && cnt_q == $past(cnt_q) + ADDR_W'(1)));
endmodule

// File: rtl/flash_eng_array.sv
module flash_eng_array #(
  parameter int ADDR_W    = 11,
  parameter bit OVERWRITE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] merged;

  generate
    if (OVERWRITE) begin : g_replace
      assign merged = prog_data;
    end else begin : g_and
      assign merged = mem[prog_addr] & prog_data;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      if (prog_en) mem[prog_addr] <= merged;
      else if (fill_en) mem[fill_addr] <= 8'hFF;
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mem[rd_addr];
    end
  end

  assert_no_port_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !(prog_en || rd_en));
endmodule

// File: rtl/flash_eng.sv
module flash_eng
  import flash_eng_pkg::*;
#(
  parameter int  SMALL_BYTES  = 64,
  parameter int  MID_BYTES    = 256,
  parameter int  SECTOR_BYTES = 512,
  parameter int  SECTOR_COUNT = 4,
  parameter bit  CAP_SMALL    = 1'b1,
  parameter bit  CAP_MID      = 1'b0,
  parameter bit  OVERWRITE    = 1'b0,
  localparam int ADDR_W       = $clog2(SECTOR_BYTES * SECTOR_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              wr_en,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              done,
  output logic              err_wp,
  output logic              warn_size
);
  req_kind_e         kind;
  logic [ADDR_W-1:0] span_mask;
  logic              unsupported;
  logic              fire, prog_en, rd_en, erase_start, fill_en;
  logic [ADDR_W-1:0] fill_addr;

  flash_eng_decode #(
    .ADDR_W(ADDR_W), .SMALL_BYTES(SMALL_BYTES), .MID_BYTES(MID_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES), .CAP_SMALL(CAP_SMALL), .CAP_MID(CAP_MID)
  ) u_decode (
    .op(req_op), .kind(kind), .span_mask(span_mask), .unsupported(unsupported)
  );

  assign req_ready   = !busy;
  assign fire        = req_valid && req_ready;
  assign prog_en     = fire && kind == KIND_PROG;
  assign rd_en       = fire && kind == KIND_READ;
  assign erase_start = fire && kind == KIND_ERASE && wr_en;

  flash_eng_eraser #(.ADDR_W(ADDR_W)) u_eraser (
    .clk(clk), .rst_n(rst_n), .start(erase_start), .addr(req_addr),
    .mask(span_mask), .busy(busy), .done(done), .fill_en(fill_en),
    .fill_addr(fill_addr)
  );

  flash_eng_array #(.ADDR_W(ADDR_W), .OVERWRITE(OVERWRITE)) u_array (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_addr(req_addr),
    .prog_data(req_data), .fill_en(fill_en), .fill_addr(fill_addr),
    .rd_en(rd_en), .rd_addr(req_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_wp    <= 1'b0;
      warn_size <= 1'b0;
    end else begin
      err_wp    <= fire && (kind == KIND_PROG || kind == KIND_ERASE) && !wr_en;
      warn_size <= fire && kind == KIND_ERASE && unsupported;
    end
  end

  assert_wp_blocks_erase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == KIND_ERASE && !wr_en) |=> (!busy && err_wp));
  assert_read_response_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == OPC_READ) |=> rd_valid);
  assert_warn_still_erases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == KIND_ERASE && unsupported && wr_en) |=> (warn_size && busy));
  assert_prog_in_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == OPC_PROG) |=> !busy);
endmodule

// File: tb/tb_flash_eng.sv
module tb_flash_eng;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_op = 8'h00;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = 8'h00;
  logic wr_en = 1'b1;
  logic req_ready, rd_valid, busy, done, err_wp, warn_size;
  logic [7:0] rd_data;
  logic o_ready, o_rd_valid, o_busy, o_done, o_err, o_warn;
  logic [7:0] o_rd_data;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_eng dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .wr_en(wr_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
    .err_wp(err_wp), .warn_size(warn_size)
  );

  flash_eng #(.OVERWRITE(1'b1)) dut_ovw (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(o_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .wr_en(wr_en),
    .rd_valid(o_rd_valid), .rd_data(o_rd_data), .busy(o_busy), .done(o_done),
    .err_wp(o_err), .warn_size(o_warn)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Offers one request, waits for acceptance, returns at the next negedge.
  task automatic issue(input logic [7:0] op, input int addr, input logic [7:0] data);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = AW'(addr);
    req_data  = data;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic read_chk(input int addr, input logic [7:0] exp, input string tag);
    issue(8'h03, addr, 8'h00);
    check(rd_valid == 1'b1, {tag, " rd_valid"}, rd_valid, 1);
    check(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic wait_erase(input int len, input string tag);
    int n = 0;
    while (busy) begin
      check(req_ready == 1'b0, {tag, " ready low while busy R8"}, req_ready, 0);
      n++;
      @(negedge clk);
    end
    check(n == len, {tag, " busy length R8"}, n, len);
    check(done == 1'b1, {tag, " done pulse R8"}, done, 1);
    @(negedge clk);
    check(done == 1'b0, {tag, " done single cycle R8"}, done, 0);
  endtask

  task automatic t_reset;
    check(busy == 1'b0 && req_ready == 1'b1, "R1 idle after reset", busy, 0);
    check(!done && !err_wp && !warn_size, "R1 flags low", {done, err_wp, warn_size}, 0);
    read_chk(0, 8'hFF, "R1 byte 0");
    read_chk(2047, 8'hFF, "R1 last byte");
    @(negedge clk);
    check(rd_valid == 1'b0, "R5 rd_valid single cycle", rd_valid, 0);
  endtask

  task automatic t_program;
    issue(8'h02, 5, 8'h0F);
    check(err_wp == 1'b0, "R4 no error when enabled", err_wp, 0);
    issue(8'h02, 5, 8'hAA);
    read_chk(5, 8'h0A, "R2 AND merge");
    check(o_rd_data == 8'hAA, "R3 overwrite replaces", o_rd_data, 8'hAA);
    wr_en = 1'b0;
    issue(8'h02, 16, 8'h3C);
    check(err_wp == 1'b1, "R4 error on protected program", err_wp, 1);
    @(negedge clk);
    check(err_wp == 1'b0, "R4 error single cycle", err_wp, 0);
    wr_en = 1'b1;
    read_chk(16, 8'h3C, "R4 protected program applied");
  endtask

  task automatic t_unknown;
    issue(8'h99, 16, 8'h00);
    check(!rd_valid && !busy && !err_wp && !warn_size, "R11 no reaction",
          {rd_valid, busy, err_wp, warn_size}, 0);
    read_chk(16, 8'h3C, "R11 array untouched");
  endtask

  task automatic t_erase_small;
    issue(8'h02, 8'h3F, 8'h00);
    issue(8'h02, 8'h40, 8'h00);
    issue(8'h02, 8'h7F, 8'h00);
    issue(8'h02, 8'h80, 8'h00);
    issue(8'h20, 8'h47, 8'h00);
    check(warn_size == 1'b0, "R10 supported size no warning", warn_size, 0);
    wait_erase(64, "small");
    read_chk(8'h40, 8'hFF, "R7 aligned start erased");
    read_chk(8'h7F, 8'hFF, "R6 small end erased");
    read_chk(8'h3F, 8'h00, "R6 below region kept");
    read_chk(8'h80, 8'h00, "R6 above region kept");
  endtask

  task automatic t_erase_mid;
    issue(8'h02, 12'h100, 8'h00);
    issue(8'h02, 12'h1FF, 8'h00);
    issue(8'h02, 12'h200, 8'h00);
    issue(8'h52, 12'h1A0, 8'h00);
    check(warn_size == 1'b1, "R10 unsupported size warns", warn_size, 1);
    wait_erase(256, "mid");
    read_chk(12'h100, 8'hFF, "R10 erase still done start");
    read_chk(12'h1FF, 8'hFF, "R6 mid end erased");
    read_chk(12'h200, 8'h00, "R6 mid neighbour kept");
  endtask

  task automatic t_protected_erase;
    wr_en = 1'b0;
    issue(8'h52, 16, 8'h00);
    check(err_wp == 1'b1, "R9 error on protected erase", err_wp, 1);
    check(warn_size == 1'b1, "R10 warning with error same edge", warn_size, 1);
    check(busy == 1'b0, "R9 no busy", busy, 0);
    wr_en = 1'b1;
    read_chk(16, 8'h3C, "R9 byte unchanged");
  endtask

  task automatic t_collision;
    int n = 0;
    issue(12'h3FF & 8'hFF, 0, 8'h00);  // unknown opcode 0xFF, no effect
    issue(8'h02, 12'h3FF, 8'h00);
    issue(8'hD8, 12'h234, 8'h00);
    check(warn_size == 1'b0, "R10 sector never warns", warn_size, 0);
    req_valid = 1'b1;
    req_op    = 8'h02;
    req_addr  = AW'(12'h3FF);
    req_data  = 8'h5A;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    check(n == 512, "R8 sector busy length", n, 512);
    check(done == 1'b1 && req_ready == 1'b1, "R8 ready with done", {done, req_ready}, 3);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b0, "R8 held request taken once", busy, 0);
    read_chk(12'h3FF, 8'h5A, "R8 program after final erase write");
    read_chk(12'h200, 8'hFF, "R6 sector start erased");
  endtask

  task automatic t_chip;
    issue(8'hC7, 12'h555, 8'h00);
    check(warn_size == 1'b0, "R10 chip never warns", warn_size, 0);
    wait_erase(2048, "chip");
    read_chk(8'h3F, 8'hFF, "R6 chip erase low byte");
    read_chk(16, 8'hFF, "R6 chip erase byte 16");
    read_chk(12'h3FF, 8'hFF, "R6 chip erase sector byte");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_unknown();
    t_erase_small();
    t_erase_mid();
    t_protected_erase();
    t_collision();
    t_chip();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule